// File: doc/BRIEF.md
# DMA Request Pin Activation Sensing

This block watches an active-low, asynchronous DMA request pin and turns it into a request for one DMA channel. The pin first passes through a two-flop synchroniser. A four-state machine then decides when a request may be raised. The request is held until the channel answers with a one-cycle accept pulse. A mode input selects one of two senses:

- **Level sense:** every accepted transfer is followed by a fresh request for as long as the pin stays low.
- **Falling-edge sense:** after each accepted transfer, the pin must be seen high before another low can count.

Edge sense works by arming on a low level, not on a true edge. As a result, a pin already held low when the channel is enabled produces the first request.

The states are:

- **ST_IDLE:** the channel is disabled.
- **ST_ARM:** waiting for a low pin.
- **ST_PEND:** a request is raised and waits for the accept pulse.
- **ST_BLOCK:** edge mode only; waiting for the pin to return high.

The transitions are:

- **enable** (ST_IDLE to ST_ARM).
- **sense_low** (ST_ARM to ST_PEND).
- **accept_level** (ST_PEND to ST_ARM, level mode).
- **accept_edge** (ST_PEND to ST_BLOCK, edge mode).
- **sense_high** (ST_BLOCK to ST_ARM).
- **disable** (any state to ST_IDLE, whenever the enable is low).

Top module: `dreq_sense`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `xfer_req` is 0 and the machine is in ST_IDLE.
- R2: With the channel enabled and in ST_ARM, a pin driven low before a rising edge raises `xfer_req` after the third rising edge and not before (two synchroniser flops plus the state register).
- R3: In level mode (`edge_mode` = 0), an accept pulse drops `xfer_req` for exactly one cycle when the pin is still low. The request is then raised again.
- R4: Once raised, `xfer_req` stays 1 until a cycle with `xfer_ack` = 1 or `chan_en` = 0, whatever the pin does.
- R5: In edge mode (`edge_mode` = 1), after an accept the machine enters ST_BLOCK. No request is raised while the pin stays low.
- R6: In edge mode, a synchronised high level in ST_BLOCK returns the machine to ST_ARM. A later low then raises `xfer_req` with the R2 timing.
- R7: A pin held low before `chan_en` rises raises `xfer_req` after the second rising edge following the enable.
- R8: When `chan_en` is 0 at a rising edge, `xfer_req` is 0 after that edge. The pin is ignored while the channel is disabled.
- R9: `xfer_ack` outside ST_PEND has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | Asynchronous active-low DMA request pin |
| chan_en | input | 1 | Channel transfer enable |
| edge_mode | input | 1 | 1 = falling-edge sense, 0 = level sense |
| xfer_ack | input | 1 | One-cycle accept pulse from the channel |
| xfer_req | output | 1 | Request to the channel, held until accepted |

## Verification
The main sweep runs both modes against an accept pulse delayed by zero to three cycles.

- The delay sweep shows that the request holds for any wait (R4).
- Keeping the pin low after the accept separates the two modes: level mode re-requests, while edge mode blocks (R3, R5).
- Releasing and lowering the pin again shows that edge mode re-arms only on a seen high (R6).

Separate patterns cover further cases:

- A pin held low before enable, which must be accepted (R7).
- An accept pulse sent outside a pending request, which must be ignored (R9).
- Activity on the pin while the channel is disabled, which must produce no request (R8).

// File: rtl/dreq_pkg.sv
package dreq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_PEND  = 2'd2,
        ST_BLOCK = 2'd3
    } sense_state_t;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[LAST-1:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[LAST];
endmodule

// File: rtl/dreq_fsm.sv
module dreq_fsm
    import dreq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin_low,
    input  logic         chan_en,
    input  logic         edge_mode,
    input  logic         xfer_ack,
    output logic         xfer_req,
    output sense_state_t state
);
    sense_state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!chan_en) begin
            state_d = ST_IDLE;                       // disable
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_ARM;          // enable
                ST_ARM:   if (pin_low) state_d = ST_PEND;   // sense_low
                ST_PEND:  if (xfer_ack)
                              state_d = edge_mode ? ST_BLOCK : ST_ARM; // accept
                ST_BLOCK: if (!pin_low) state_d = ST_ARM;   // sense_high
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        xfer_req = 1'b0;
        unique case (state_q)
            ST_PEND: xfer_req = 1'b1;
            ST_IDLE, ST_ARM, ST_BLOCK: xfer_req = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/dreq_sense.sv
module dreq_sense
    import dreq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic chan_en,
    input  logic edge_mode,
    input  logic xfer_ack,
    output logic xfer_req
);
    logic         pin_sync;
    sense_state_t state_w;

    dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_n),
        .dout  (pin_sync)
    );

    dreq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_low   (~pin_sync),
        .chan_en   (chan_en),
        .edge_mode (edge_mode),
        .xfer_ack  (xfer_ack),
        .xfer_req  (xfer_req),
        .state     (state_w)
    );
endmodule

// File: rtl/dreq_sense_chk.sv
module dreq_sense_chk
    import dreq_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         pin_sync,
    input logic         chan_en,
    input logic         edge_mode,
    input logic         xfer_ack,
    input logic         xfer_req,
    input sense_state_t state_w
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!xfer_req && state_w == ST_IDLE));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack && chan_en) |=> xfer_req);

    // R3
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack) |=> !xfer_req);

    // R8
    disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (!xfer_req && state_w == ST_IDLE));

    // R2
    rise_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_req) |-> $past(!pin_sync && chan_en));

    // R5
    edge_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_BLOCK && !pin_sync && chan_en) |=> !xfer_req);

    // R9
    ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_ARM && chan_en && pin_sync && xfer_ack) |=> state_w == ST_ARM);
endmodule

bind dreq_sense dreq_sense_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_sync  (pin_sync),
    .chan_en   (chan_en),
    .edge_mode (edge_mode),
    .xfer_ack  (xfer_ack),
    .xfer_req  (xfer_req),
    .state_w   (state_w)
);

// File: tb/sim_dreq_sense.sv
`timescale 1ns/1ps
module sim_dreq_sense;
    logic clk = 1'b0;
    logic rst_n, pin_n, chan_en, edge_mode, xfer_ack;
    logic xfer_req;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dreq_sense u0 (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .chan_en(chan_en),
        .edge_mode(edge_mode), .xfer_ack(xfer_ack), .xfer_req(xfer_req)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic exp, input string tag);
        checks++;
        if (xfer_req !== exp) begin
            errors++;
            $display("FAIL %s: xfer_req=%b expected %b", tag, xfer_req, exp);
        end
    endtask

    task automatic pulse_ack();
        xfer_ack = 1'b1;
        step(1);
        xfer_ack = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; pin_n = 1'b1; chan_en = 1'b0; edge_mode = 1'b0; xfer_ack = 1'b0;
        step(1);
        check(1'b0, "R1 in reset");
        rst_n = 1'b1;
        step(1);
        check(1'b0, "R1 after reset");

        // R8: pin activity while disabled is ignored
        pin_n = 1'b0;
        step(4);
        check(1'b0, "R8 disabled pin low");
        // R7: pre-held low accepted on enable, second edge
        chan_en = 1'b1;
        step(1);
        check(1'b0, "R7 one edge after enable");
        step(1);
        check(1'b1, "R7 two edges after enable");
        chan_en = 1'b0;
        step(1);
        check(1'b0, "R8 disable drops request");
        pin_n = 1'b1;
        step(3);

        // R9: ack while armed, pin high, is ignored
        chan_en = 1'b1;
        step(2);
        pulse_ack();
        check(1'b0, "R9 ack in arm");
        pin_n = 1'b0;
        step(3);
        check(1'b1, "R9 still armed after stray ack");
        chan_en = 1'b0; pin_n = 1'b1;
        step(3);

        // sweep: mode x ack delay
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 4; d++) begin
                edge_mode = m[0];
                chan_en = 1'b1;
                step(2);
                pin_n = 1'b0;
                step(2);
                check(1'b0, "R2 not before third edge");
                step(1);
                check(1'b1, "R2 third edge");
                pin_n = (d % 2 == 1) ? 1'b1 : 1'b0;   // pin wiggle must not matter
                step(d);
                check(1'b1, "R4 held until accept");
                pin_n = 1'b0;
                step(2);
                pulse_ack();
                check(1'b0, "R3 R5 drop after accept");
                step(1);
                if (m == 0) check(1'b1, "R3 level re-request");
                else        check(1'b0, "R5 edge blocked");
                step(3);
                if (m == 0) begin
                    check(1'b1, "R3 level held");
                end else begin
                    check(1'b0, "R5 edge still blocked");
                    pulse_ack();
                    check(1'b0, "R9 ack in block");
                    pin_n = 1'b1;
                    step(3);
                    check(1'b0, "R6 high re-arms without request");
                    pin_n = 1'b0;
                    step(2);
                    check(1'b0, "R6 not before third edge");
                    step(1);
                    check(1'b1, "R6 new request after re-arm");
                end
                chan_en = 1'b0;
                step(1);
                check(1'b0, "R8 disable drops request");
                pin_n = 1'b1;
                step(3);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule